// File: doc/BRIEF.md
# Four-Channel DMA Trigger Scheduler

This block tracks which of four DMA channels have work waiting and picks the channel that runs the next single-unit transfer. Software programs each channel with an enable bit, a two-bit trigger mode, an interrupt-enable bit and, on the last channel, a request-flag bit. Display timing events (vertical blank, horizontal blank) and a special trigger reserved for the last channel turn enabled channels into waiting ones. Enabling a channel in immediate mode makes it wait at once.

The scheduler issues a one-cycle start pulse with a channel index to a transfer sequencer. It then waits for that sequencer to report that the unit is done, and whether the unit ended the channel's block. After every unit it scans again from channel 0, so a more urgent channel that became ready in the meantime gets the bus between two units of a less urgent one. Interrupt flags are raised per unit and stay set until software clears them by writing ones.

Top module: `dma_trig_sched`

## Requirements
- R1: After reset, start_pulse and busy are 0, irq_flags is all zeros and cart_irq is 0.
- R2: When several channels are waiting, the start pulse names the lowest-numbered one (channel 0 is the most urgent). start_ch is a binary channel index.
- R3: After every unit_done the scheduler scans again from channel 0, so a channel that became waiting while a unit of a higher-numbered channel was in flight runs before that channel's next unit.
- R4: busy is 1 from the cycle of a start pulse until a scan finds no channel waiting, and 0 otherwise.
- R5: A vblank_pulse makes every enabled channel whose trigger mode (bits [2n+1:2n] of ch_mode) is 1 wait.
- R6: An hblank_pulse makes every enabled channel whose trigger mode is 2 wait.
- R7: A special_pulse makes only channel 3 wait, and only when it is enabled with mode 3. Mode 3 on channels 0 to 2 never triggers.
- R8: Mode 0 is immediate: a channel starts waiting when its enable bit goes from 0 to 1 while its mode is 0.
- R9: A waiting channel stays waiting across units and stops waiting when unit_done arrives together with block_done. A channel whose block is N units long therefore gets exactly N start pulses.
- R10: When a unit on channel n completes (unit_done) and its ch_irq_en bit is set, irq_flags bit n becomes 1 on the next cycle.
- R11: When a unit on channel 3 completes with drq_en set, cart_irq becomes 1 on the next cycle.
- R12: irq_flags and cart_irq are sticky. They clear only for bits written with 1 on irq_clr / cart_clr, and a set in the same cycle wins over the clear.
- R13: Triggers that arrive while a channel is already waiting are merged and add no extra units.
- R14: No second start pulse is issued until unit_done for the current unit has arrived, so two starts are never back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_mode | input | 2*NUM_CH | Per-channel trigger mode, 0 immediate, 1 vblank, 2 hblank, 3 special |
| ch_irq_en | input | NUM_CH | Per-channel interrupt enable |
| drq_en | input | 1 | Request-flag bit of channel 3 |
| vblank_pulse | input | 1 | Vertical-blank event |
| hblank_pulse | input | 1 | Horizontal-blank event |
| special_pulse | input | 1 | Special trigger event for channel 3 |
| unit_done | input | 1 | Sequencer finished the current unit |
| block_done | input | 1 | Qualifies unit_done: the unit was the last of the block |
| irq_clr | input | NUM_CH | Write-one-to-clear for irq_flags |
| cart_clr | input | 1 | Write-one-to-clear for cart_irq |
| start_pulse | output | 1 | One-cycle start of a unit |
| start_ch | output | IDX_W | Channel of the unit being started |
| busy | output | 1 | Scheduler active |
| irq_flags | output | NUM_CH | Sticky per-channel interrupt flags |
| cart_irq | output | 1 | Sticky cartridge interrupt flag |

## Verification
Two channels released by the same vertical blank show whether the lowest index wins and whether each receives exactly its block length of units. A horizontal blank with a vertical-blank channel standing by, and a special pulse with channel 0 parked in mode 3, tell apart correct event-to-mode matching from triggers that leak to other channels. An immediate-mode block on channel 3 interrupted by a vertical blank for channel 1 separates a scheduler that rescans after each unit from one that finishes a block first. Repeated horizontal blanks during a slow block tell merging apart from counting triggers.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;

  typedef enum logic [1:0] {
    TM_IMM = 2'd0,
    TM_VBL = 2'd1,
    TM_HBL = 2'd2,
    TM_SPC = 2'd3
  } trig_mode_e;

  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_WAIT = 1'b1
  } sched_state_e;

endpackage

// File: rtl/dma_trig_pend.sv
module dma_trig_pend
  import dma_trig_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SPC_CH = NUM_CH - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     ch_en,
  input  logic [2*NUM_CH-1:0]   ch_mode,
  input  logic                  vblank_pulse,
  input  logic                  hblank_pulse,
  input  logic                  special_pulse,
  input  logic [NUM_CH-1:0]     clr_vec,
  output logic [NUM_CH-1:0]     pend_vec
);

  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] trig;
  logic [NUM_CH-1:0] pend_d;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    trig_mode_e mode;
    logic       spc_hit;
    assign mode = trig_mode_e'(ch_mode[2*g +: 2]);

    if (g == SPC_CH) begin : g_spc
      assign spc_hit = special_pulse && (mode == TM_SPC);
    end else begin : g_nospc
      assign spc_hit = 1'b0;
    end

    assign trig[g] = ch_en[g] &&
                     ((vblank_pulse && (mode == TM_VBL)) ||
                      (hblank_pulse && (mode == TM_HBL)) ||
                      (!en_q[g]     && (mode == TM_IMM)) ||
                      spc_hit);

    // a fresh trigger wins over a same-cycle block completion
    assign pend_d[g] = trig[g] | (pend_vec[g] & ~clr_vec[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      pend_vec <= '0;
    end else begin
      en_q     <= ch_en;
      pend_vec <= pend_d;
    end
  end

endmodule

// File: rtl/dma_trig_arb.sv
module dma_trig_arb #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_CH-1:0] req,
  output logic              grant_vld,
  output logic [IDX_W-1:0]  grant_idx
);

  always_comb begin
    grant_vld = |req;
    grant_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) grant_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/dma_trig_irq.sv
module dma_trig_irq #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2,
  parameter int SPC_CH = NUM_CH - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_ack,
  input  logic [IDX_W-1:0]  cur_ch,
  input  logic [NUM_CH-1:0] ch_irq_en,
  input  logic              drq_en,
  input  logic [NUM_CH-1:0] irq_clr,
  input  logic              cart_clr,
  output logic [NUM_CH-1:0] irq_flags,
  output logic              cart_irq
);

  logic [NUM_CH-1:0] set_vec;
  logic [NUM_CH-1:0] flags_d;
  logic              cart_set;
  logic              cart_d;
  logic              flags_ce;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_set
    assign set_vec[g] = unit_ack && ch_irq_en[g] && (cur_ch == IDX_W'(g));
  end

  assign cart_set = unit_ack && drq_en && (cur_ch == IDX_W'(SPC_CH));

  always_comb begin
    flags_d  = set_vec | (irq_flags & ~irq_clr);
    cart_d   = cart_set | (cart_irq & ~cart_clr);
    flags_ce = unit_ack | (|irq_clr) | cart_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flags <= '0;
      cart_irq  <= 1'b0;
    end else if (flags_ce) begin
      irq_flags <= flags_d;
      cart_irq  <= cart_d;
    end
  end

endmodule

// File: rtl/dma_trig_sched.sv
module dma_trig_sched
  import dma_trig_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   ch_en,
  input  logic [2*NUM_CH-1:0] ch_mode,
  input  logic [NUM_CH-1:0]   ch_irq_en,
  input  logic                drq_en,
  input  logic                vblank_pulse,
  input  logic                hblank_pulse,
  input  logic                special_pulse,
  input  logic                unit_done,
  input  logic                block_done,
  input  logic [NUM_CH-1:0]   irq_clr,
  input  logic                cart_clr,
  output logic                start_pulse,
  output logic [IDX_W-1:0]    start_ch,
  output logic                busy,
  output logic [NUM_CH-1:0]   irq_flags,
  output logic                cart_irq
);

  localparam int SPC_CH = NUM_CH - 1;

  sched_state_e      st_q, st_d;
  logic [IDX_W-1:0]  cur_q;
  logic [NUM_CH-1:0] pend_vec;
  logic [NUM_CH-1:0] clr_vec;
  logic              grant_vld;
  logic [IDX_W-1:0]  grant_idx;
  logic              unit_ack;
  logic              start_d;

  dma_trig_pend #(
    .NUM_CH (NUM_CH),
    .SPC_CH (SPC_CH)
  ) u_pend (
    .clk           (clk),
    .rst_n         (rst_n),
    .ch_en         (ch_en),
    .ch_mode       (ch_mode),
    .vblank_pulse  (vblank_pulse),
    .hblank_pulse  (hblank_pulse),
    .special_pulse (special_pulse),
    .clr_vec       (clr_vec),
    .pend_vec      (pend_vec)
  );

  dma_trig_arb #(
    .NUM_CH (NUM_CH),
    .IDX_W  (IDX_W)
  ) u_arb (
    .req       (pend_vec),
    .grant_vld (grant_vld),
    .grant_idx (grant_idx)
  );

  assign unit_ack = (st_q == ST_WAIT) && unit_done;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_clr
    assign clr_vec[g] = unit_ack && block_done && (cur_q == IDX_W'(g));
  end

  dma_trig_irq #(
    .NUM_CH (NUM_CH),
    .IDX_W  (IDX_W),
    .SPC_CH (SPC_CH)
  ) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .unit_ack  (unit_ack),
    .cur_ch    (cur_q),
    .ch_irq_en (ch_irq_en),
    .drq_en    (drq_en),
    .irq_clr   (irq_clr),
    .cart_clr  (cart_clr),
    .irq_flags (irq_flags),
    .cart_irq  (cart_irq)
  );

  // next-state logic: scan after every unit, wait for the sequencer otherwise
  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    unique case (st_q)
      ST_SCAN: begin
        if (grant_vld) begin
          start_d = 1'b1;
          st_d    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (unit_done) st_d = ST_SCAN;
      end
      default: st_d = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SCAN;
      cur_q <= '0;
    end else begin
      st_q <= st_d;
      if (start_d) cur_q <= grant_idx;
    end
  end

  assign start_pulse = start_d;
  assign start_ch    = grant_idx;
  assign busy        = (st_q == ST_WAIT) || grant_vld;

endmodule

// File: rtl/dma_trig_sched_chk.sv
module dma_trig_sched_chk #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_pulse,
  input logic [IDX_W-1:0]  start_ch,
  input logic              busy,
  input logic              unit_done,
  input logic [NUM_CH-1:0] pend_vec,
  input logic [NUM_CH-1:0] irq_flags,
  input logic [NUM_CH-1:0] irq_clr,
  input logic              cart_irq
);

  logic [NUM_CH-1:0] lower_mask;
  always_comb begin
    lower_mask = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (IDX_W'(i) < start_ch) lower_mask[i] = 1'b1;
    end
  end

  AST_START_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (pend_vec[start_ch] && ((pend_vec & lower_mask) == '0))); // R2

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> busy); // R4

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R14

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_flags & ~irq_clr) != '0) |=>
      ((irq_flags & $past(irq_flags & ~irq_clr)) == $past(irq_flags & ~irq_clr))); // R12

  AST_FLAG_FROM_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_flags & ~$past(irq_flags)) != '0) |-> $past(unit_done)); // R10

  AST_CART_FROM_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cart_irq) |-> $past(unit_done)); // R11

endmodule

bind dma_trig_sched dma_trig_sched_chk #(
  .NUM_CH (NUM_CH),
  .IDX_W  (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_pulse (start_pulse),
  .start_ch    (start_ch),
  .busy        (busy),
  .unit_done   (unit_done),
  .pend_vec    (pend_vec),
  .irq_flags   (irq_flags),
  .irq_clr     (irq_clr),
  .cart_irq    (cart_irq)
);

// File: tb/dma_trig_sched_test.sv
`timescale 1ns/1ps
module dma_trig_sched_test;

  logic       clk;
  logic       rst_n;
  logic [3:0] en, ien, iclr;
  logic [7:0] tm;
  logic       drq, vbl, hbl, spc, ud, bd, cclr;
  logic       start_pulse, busy, cart_irq;
  logic [1:0] start_ch;
  logic [3:0] irq_flags;

  int checks = 0;
  int errors = 0;

  dma_trig_sched uut (
    .clk(clk), .rst_n(rst_n), .ch_en(en), .ch_mode(tm), .ch_irq_en(ien),
    .drq_en(drq), .vblank_pulse(vbl), .hblank_pulse(hbl), .special_pulse(spc),
    .unit_done(ud), .block_done(bd), .irq_clr(iclr), .cart_clr(cclr),
    .start_pulse(start_pulse), .start_ch(start_ch), .busy(busy),
    .irq_flags(irq_flags), .cart_irq(cart_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_pend[4];
  bit       m_wait;
  int       m_cur;
  bit [3:0] m_enq;
  bit [3:0] m_flags;
  bit       m_cart;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pend[i]) m_pend[i] = 0;
      m_wait = 0; m_cur = 0; m_enq = '0; m_flags = '0; m_cart = 0;
    end else begin
      bit np[4];
      int win;
      for (int c = 0; c < 4; c++) begin
        int  md;
        bit  t;
        md = int'(tm[2*c +: 2]);
        t  = en[c] && ((md == 1 && vbl) || (md == 2 && hbl) ||
                       (md == 0 && !m_enq[c]) || (c == 3 && md == 3 && spc));
        np[c] = t ? 1'b1 : ((m_wait && ud && bd && m_cur == c) ? 1'b0 : m_pend[c]);
      end
      m_flags = m_flags & ~iclr;
      m_cart  = m_cart & ~cclr;
      if (m_wait && ud) begin
        if (ien[m_cur]) m_flags[m_cur] = 1'b1;
        if (m_cur == 3 && drq) m_cart = 1'b1;
      end
      win = -1;
      for (int c = 3; c >= 0; c--) if (m_pend[c]) win = c;
      if (!m_wait) begin
        if (win >= 0) begin m_wait = 1; m_cur = win; end
      end else if (ud) m_wait = 0;
      foreach (np[c]) m_pend[c] = np[c];
      m_enq = en;
    end
  end

  // ---------------- per-cycle comparison and start bookkeeping ----------------
  int  cnt[4];
  int  ord[$];
  bit  prev_start;
  bit  b2b_seen;

  always @(negedge clk) begin
    if (rst_n) begin
      int  w;
      bit  e_start, e_busy;
      w = -1;
      for (int c = 3; c >= 0; c--) if (m_pend[c]) w = c;
      e_start = !m_wait && (w >= 0);
      e_busy  = m_wait || (w >= 0);
      check(start_pulse == e_start, "R3 start_pulse", int'(start_pulse), int'(e_start));
      if (e_start)
        check(int'(start_ch) == w, "R2 start_ch", int'(start_ch), w);
      check(busy == e_busy, "R4 busy", int'(busy), int'(e_busy));
      check(irq_flags == m_flags, "R10 irq_flags", int'(irq_flags), int'(m_flags));
      check(cart_irq == m_cart, "R11 cart_irq", int'(cart_irq), int'(m_cart));
      if (start_pulse) begin
        cnt[start_ch]++;
        ord.push_back(int'(start_ch));
        if (prev_start) b2b_seen = 1;
      end
      prev_start = start_pulse;
    end
  end

  // ---------------- bench sequencer ----------------
  int len[4];
  int rem[4];
  int dly;
  int extra;
  int scur;

  always @(negedge clk) begin
    if (!rst_n) begin
      ud <= 0; bd <= 0; dly = 0;
      foreach (rem[i]) rem[i] = 0;
    end else begin
      if (ud) begin ud <= 0; bd <= 0; end
      if (dly > 0) begin
        dly--;
        if (dly == 0) begin
          rem[scur]--;
          ud <= 1;
          bd <= (rem[scur] == 0);
        end
      end
      if (start_pulse) begin
        scur = int'(start_ch);
        if (rem[scur] == 0) rem[scur] = len[scur];
        dly = extra + 1;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic wait_idle();
    int q = 0;
    int t = 0;
    while (q < 4 && t < 2000) begin
      @(negedge clk);
      t++;
      if (!busy) q++; else q = 0;
    end
  endtask

  task automatic quiesce();
    @(negedge clk);
    en = '0; ien = '0; drq = 0; tm = '0;
    repeat (2) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    int b[4];
    int first;
    bit mid;
    en = '0; ien = '0; iclr = '0; tm = '0; drq = 0;
    vbl = 0; hbl = 0; spc = 0; cclr = 0;
    extra = 0;
    foreach (len[i]) len[i] = 1;
    foreach (cnt[i]) cnt[i] = 0;
    prev_start = 0; b2b_seen = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(start_pulse == 0 && busy == 0, "R1 reset outputs", int'(busy), 0);
    check(irq_flags == 0 && cart_irq == 0, "R1 reset flags", int'(irq_flags), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // S1: vblank releases ch0 (len 2) and ch1 (len 3)
    len[0] = 2; len[1] = 3;
    tm = 8'b00_00_01_01; en = 4'b0011; ien = 4'b0001;
    repeat (2) @(negedge clk);
    check(cnt[0] == 0 && cnt[1] == 0, "R8 no start for non-immediate enable", cnt[0] + cnt[1], 0);
    first = ord.size();
    pulse(vbl);
    wait_idle();
    check(ord[first] == 0, "R2 lowest index first", ord[first], 0);
    check(cnt[0] == 2, "R9 ch0 units", cnt[0], 2);
    check(cnt[1] == 3, "R5 ch1 units", cnt[1], 3);
    check(irq_flags == 4'b0001, "R10 flag only on enabled channel", int'(irq_flags), 1);
    quiesce();

    // S2: hblank with a vblank channel standing by
    foreach (cnt[i]) b[i] = cnt[i];
    len[2] = 2;
    tm = 8'b00_10_00_01; en = 4'b0101;
    @(negedge clk);
    pulse(hbl);
    wait_idle();
    check(cnt[2] - b[2] == 2, "R6 ch2 units", cnt[2] - b[2], 2);
    check(cnt[0] - b[0] == 0, "R6 vblank channel untouched", cnt[0] - b[0], 0);
    quiesce();

    // S3: special trigger with ch0 parked in mode 3
    foreach (cnt[i]) b[i] = cnt[i];
    len[3] = 1;
    tm = 8'b11_00_00_11; en = 4'b1001; drq = 1;
    @(negedge clk);
    pulse(spc);
    wait_idle();
    check(cnt[3] - b[3] == 1, "R7 ch3 special units", cnt[3] - b[3], 1);
    check(cnt[0] - b[0] == 0, "R7 mode 3 ignored on ch0", cnt[0] - b[0], 0);
    check(cart_irq == 1, "R11 cartridge flag", int'(cart_irq), 1);
    quiesce();

    // S4: immediate block on ch3 preempted by vblank on ch1
    foreach (cnt[i]) b[i] = cnt[i];
    len[3] = 4; len[1] = 1; extra = 2;
    tm = 8'b00_00_01_00; en = 4'b0010;
    @(negedge clk);
    first = ord.size();
    en = 4'b1010;
    while (cnt[3] == b[3]) @(negedge clk);
    pulse(vbl);
    wait_idle();
    mid = 0;
    for (int i = first + 1; i < ord.size() - 1; i++) if (ord[i] == 1) mid = 1;
    check(mid, "R3 ch1 runs between ch3 units", int'(mid), 1);
    check(cnt[3] - b[3] == 4, "R8 immediate block units", cnt[3] - b[3], 4);
    check(cnt[1] - b[1] == 1, "R3 preempting channel units", cnt[1] - b[1], 1);
    quiesce();

    // S5: repeated hblank during a slow block merges
    foreach (cnt[i]) b[i] = cnt[i];
    len[2] = 3; extra = 3;
    tm = 8'b00_10_00_00; en = 4'b0100;
    @(negedge clk);
    pulse(hbl);
    repeat (2) @(negedge clk);
    pulse(hbl);
    repeat (2) @(negedge clk);
    pulse(hbl);
    wait_idle();
    check(cnt[2] - b[2] == 3, "R13 merged triggers", cnt[2] - b[2], 3);
    quiesce();
    extra = 0;

    // S6: write-one-to-clear
    @(negedge clk); iclr = 4'b0001;
    @(negedge clk); iclr = 4'b0000;
    @(negedge clk);
    check(irq_flags[0] == 0, "R12 flag cleared", int'(irq_flags[0]), 0);
    check(cart_irq == 1, "R12 cartridge flag kept", int'(cart_irq), 1);
    @(negedge clk); cclr = 1;
    @(negedge clk); cclr = 0;
    @(negedge clk);
    check(cart_irq == 0, "R12 cartridge flag cleared", int'(cart_irq), 0);

    check(!b2b_seen, "R14 no back-to-back starts", int'(b2b_seen), 0);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule